// File: doc/BRIEF.md
# Serial PHY Management Frame Master

This block runs one register access at a time on a two-wire serial management bus toward an attached Ethernet PHY. The host side raises a one-cycle start request. With it come a read/write select, a 5-bit PHY address, a 5-bit register number and, for writes, a 16-bit value. The block then drives the whole frame on the line side: a management clock, a data output, the enable for the external data driver, and a data input that it samples. When the last clock of the frame is over, it returns the lines to idle and raises a single-cycle done pulse. For a read, the 16-bit result is valid on the read-data output from that pulse onwards.

The clock rate on the line is set by the parameter `HALF_DIV`. This is the number of system-clock cycles in each half of a management clock period. A read frame is always 64 bit times long and a write frame is always 65. A frame starts in the cycle after the request is accepted. While a frame is in progress, any further start request is dropped.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset, the management clock, data output, output enable and done are all low, and the read data is 0x0000.
- R2: Every frame opens with 32 bit times in which the output enable and the data output are both high.
- R3: The preamble is followed by two bit times driven 0 and then 1. Next come two opcode bit times: 1 then 0 for a read, and 0 then 1 for a write. All four are driven.
- R4: The opcode is followed by the 5 PHY address bits and then the 5 register number bits. Both fields are sent most significant bit first with the output enabled.
- R5: A read frame continues with one undriven turnaround bit time, then 16 undriven sampling bit times, then one undriven final bit time, for 64 bit times in total.
- R6: A write frame continues with two undriven turnaround bit times, then the 16 write-data bits driven most significant bit first, then one undriven final bit time, for 65 bit times in total.
- R7: The first bit time starts in the cycle after the start request is accepted. In each bit time, the management clock is low for `HALF_DIV` system cycles and then high for `HALF_DIV` system cycles, and the output enable and data output stay constant for the whole bit time.
- R8: The data input passes through a two-stage synchronizer. A read result holds the 16 values present in the bit times right after the turnaround bit; the first of these becomes bit 15 of the result. Input values in any other bit time have no effect on the result, and a write frame leaves the read data unchanged.
- R9: The done output is high for exactly one cycle. That cycle comes directly after the last bit time, and the lines are idle in it. The read data then stays unchanged until the next read completes.
- R10: A start request that arrives while a frame is in progress is ignored, and the frame on the line continues unchanged.
- R11: The data output is low in every cycle in which the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a frame; accepted only when idle |
| is_write_i | input | 1 | 1 selects a write frame, 0 selects a read frame |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register number |
| wdata_i | input | 16 | Value to write |
| rdata_o | output | 16 | Result of the last completed read |
| done_o | output | 1 | One-cycle pulse when a frame has finished |
| mdc_o | output | 1 | Management clock |
| mdo_o | output | 1 | Serial data toward the PHY |
| mdoe_o | output | 1 | Enable for the external data driver |
| mdi_i | input | 1 | Serial data from the PHY (asynchronous) |

## Verification
The bench builds the block with `HALF_DIV` = 3. Because this is odd and larger than the minimum, the divider wraps at a count that is not a power of two, and each management clock half lasts several system cycles, so a data bit that changed while a phase was still open would be caught. With three cycles per half, the value taken from the synchronizer comes from inside the same bit time, so the bench can drive a different junk value on the data input in every bit time outside the read window and see that none of it reaches the result. Start requests with opposite fields are injected in the middle of frames, and the bench then checks that the line sequence is unchanged.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PREAMBLE_BITS = 32;
    localparam int DATA_BITS     = 16;
    localparam int FIELD_BITS    = 5;
    // index of first bit time after the register number
    localparam int HDR_END       = PREAMBLE_BITS + 4 + 2 * FIELD_BITS;
    localparam int RD_DATA_FIRST = HDR_END + 1;
    localparam int RD_DATA_LAST  = RD_DATA_FIRST + DATA_BITS - 1;
    localparam int WR_DATA_FIRST = HDR_END + 2;
    localparam int WR_DATA_LAST  = WR_DATA_FIRST + DATA_BITS - 1;
    localparam int RD_LAST_IDX   = RD_DATA_LAST + 1;
    localparam int WR_LAST_IDX   = WR_DATA_LAST + 1;
    localparam int IDX_W         = $clog2(WR_LAST_IDX + 1);

    typedef logic [IDX_W-1:0] bit_idx_t;

    typedef struct packed {
        logic                  is_write;
        logic [FIELD_BITS-1:0] phy;
        logic [FIELD_BITS-1:0] regn;
        logic [DATA_BITS-1:0]  wdata;
    } mgmt_req_t;

    typedef struct packed {
        logic oe;
        logic o;
    } line_t;

    function automatic bit_idx_t last_idx(input logic is_write);
        return is_write ? IDX_W'(WR_LAST_IDX) : IDX_W'(RD_LAST_IDX);
    endfunction

    function automatic logic in_read_window(input bit_idx_t i);
        return (int'(i) >= RD_DATA_FIRST) && (int'(i) <= RD_DATA_LAST);
    endfunction

    // line drive for bit time i of frame r
    function automatic line_t line_bit(input mgmt_req_t r, input bit_idx_t i);
        line_t l;
        int    n;
        n = int'(i);
        l = '{oe: 1'b0, o: 1'b0};
        if (n < PREAMBLE_BITS) begin
            l = '{oe: 1'b1, o: 1'b1};
        end else if (n == PREAMBLE_BITS) begin
            l = '{oe: 1'b1, o: 1'b0};
        end else if (n == PREAMBLE_BITS + 1) begin
            l = '{oe: 1'b1, o: 1'b1};
        end else if (n == PREAMBLE_BITS + 2) begin
            l = '{oe: 1'b1, o: !r.is_write};
        end else if (n == PREAMBLE_BITS + 3) begin
            l = '{oe: 1'b1, o: r.is_write};
        end else if (n < PREAMBLE_BITS + 4 + FIELD_BITS) begin
            l = '{oe: 1'b1, o: r.phy[3'(PREAMBLE_BITS + 3 + FIELD_BITS - n)]};
        end else if (n < HDR_END) begin
            l = '{oe: 1'b1, o: r.regn[3'(HDR_END - 1 - n)]};
        end else if (r.is_write && n >= WR_DATA_FIRST && n <= WR_DATA_LAST) begin
            l = '{oe: 1'b1, o: r.wdata[4'(WR_DATA_LAST - n)]};
        end
        return l;
    endfunction

endpackage

// File: rtl/mdio_half_tick.sv
module mdio_half_tick #(
    parameter int HALF_DIV = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == CW'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R7
    half_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt_q == '0));

endmodule

// File: rtl/mdio_in_sync.sv
module mdio_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[STAGES-2:0], d};
        end
    end

    assign q = sh_q[STAGES-1];

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  mgmt_req_t            req_in,
    input  logic                 tick,
    input  logic                 mdi_s,
    output logic                 busy,
    output logic                 phase,
    output bit_idx_t             idx,
    output mgmt_req_t            req,
    output logic [DATA_BITS-1:0] rdata,
    output logic                 done
);
    logic                 busy_q;
    logic                 phase_q;
    bit_idx_t             idx_q;
    mgmt_req_t            req_q;
    logic [DATA_BITS-1:0] rdata_q;
    logic                 done_q;
    logic                 sample_now;

    assign sample_now = busy_q && tick && phase_q && !req_q.is_write
                        && in_read_window(idx_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            phase_q <= 1'b0;
            idx_q   <= '0;
            req_q   <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q  <= 1'b1;
                    phase_q <= 1'b0;
                    idx_q   <= '0;
                    req_q   <= req_in;
                end
            end else if (tick) begin
                phase_q <= !phase_q;
                if (phase_q) begin
                    if (idx_q == last_idx(req_q.is_write)) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
            end
            if (sample_now) begin
                rdata_q <= {rdata_q[DATA_BITS-2:0], mdi_s};
            end
        end
    end

    assign busy  = busy_q;
    assign phase = phase_q;
    assign idx   = idx_q;
    assign req   = req_q;
    assign rdata = rdata_q;
    assign done  = done_q;

    // R10
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && start) |=> $stable(req_q));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    // R9
    done_after_frame_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (!busy_q && $past(busy_q)));
    // R7
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !tick) |=> ($stable(phase_q) && $stable(idx_q)));
    // R5
    idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (idx_q <= last_idx(req_q.is_write)));
    // R8
    write_keeps_rdata_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && req_q.is_write) |=> $stable(rdata_q));

endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        is_write_i,
    input  logic [4:0]  phy_addr_i,
    input  logic [4:0]  reg_addr_i,
    input  logic [15:0] wdata_i,
    output logic [15:0] rdata_o,
    output logic        done_o,
    output logic        mdc_o,
    output logic        mdo_o,
    output logic        mdoe_o,
    input  logic        mdi_i
);
    logic      tick;
    logic      mdi_s;
    logic      busy;
    logic      phase;
    bit_idx_t  idx;
    mgmt_req_t req_in;
    mgmt_req_t req;
    line_t     drive;

    assign req_in = '{is_write: is_write_i, phy: phy_addr_i,
                      regn: reg_addr_i, wdata: wdata_i};

    mdio_half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (tick)
    );

    mdio_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (mdi_i),
        .q   (mdi_s)
    );

    mdio_frame_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start_i),
        .req_in (req_in),
        .tick   (tick),
        .mdi_s  (mdi_s),
        .busy   (busy),
        .phase  (phase),
        .idx    (idx),
        .req    (req),
        .rdata  (rdata_o),
        .done   (done_o)
    );

    always_comb begin
        drive = '{oe: 1'b0, o: 1'b0};
        if (busy) begin
            drive = line_bit(req, idx);
        end
    end

    assign mdc_o  = busy && phase;
    assign mdoe_o = drive.oe;
    assign mdo_o  = drive.o;

    // R11
    mdo_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !mdoe_o |-> !mdo_o);
    // R9
    idle_at_done_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!mdc_o && !mdoe_o && !mdo_o));

endmodule

// File: tb/mdio_frame_master_tb.sv
module mdio_frame_master_tb;
    localparam int HD = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        is_write_i = 1'b0;
    logic [4:0]  phy_addr_i = '0;
    logic [4:0]  reg_addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic [15:0] rdata_o;
    logic        done_o, mdc_o, mdo_o, mdoe_o;
    logic        mdi_i = 1'b0;

    always #2 clk = ~clk;

    mdio_frame_master #(.HALF_DIV(HD)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .is_write_i(is_write_i),
        .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .done_o(done_o), .mdc_o(mdc_o), .mdo_o(mdo_o),
        .mdoe_o(mdoe_o), .mdi_i(mdi_i)
    );

    typedef struct {
        bit    c;
        bit    oe;
        bit    o;
        bit    mi;
        string tag;
    } ent_t;

    ent_t        q[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    int          junk = 0;
    bit          pend = 0;
    bit          pend_is_rd = 0;
    logic [15:0] pend_rd = '0;
    logic [15:0] exp_rd = '0;
    string       note = "";

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit jb();
        junk++;
        return junk[0] ^ junk[2];
    endfunction

    // one bit time: HD low cycles then HD high cycles, lines constant (R7)
    task automatic push_bit(input bit oe, input bit o, input bit mi, input string tag);
        for (int k = 0; k < 2 * HD; k++) begin
            ent_t e;
            e.c = (k >= HD);
            e.oe = oe;
            e.o = o;
            e.mi = mi;
            e.tag = tag;
            q.push_back(e);
        end
    endtask

    task automatic build(input bit w, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd, input logic [15:0] rd);
        for (int i = 0; i < 32; i++) push_bit(1, 1, jb(), "R2");
        push_bit(1, 0, jb(), "R3");
        push_bit(1, 1, jb(), "R3");
        push_bit(1, !w, jb(), "R3");
        push_bit(1, w, jb(), "R3");
        for (int i = 4; i >= 0; i--) push_bit(1, pa[i], jb(), "R4");
        for (int i = 4; i >= 0; i--) push_bit(1, ra[i], jb(), "R4");
        if (!w) begin
            push_bit(0, 0, jb(), "R5");
            for (int i = 15; i >= 0; i--) push_bit(0, 0, rd[i], "R8");
            push_bit(0, 0, jb(), "R5");
        end else begin
            push_bit(0, 0, jb(), "R6");
            push_bit(0, 0, jb(), "R6");
            for (int i = 15; i >= 0; i--) push_bit(1, wd[i], jb(), "R6");
            push_bit(0, 0, jb(), "R6");
        end
    endtask

    task automatic run_frame(input bit w, input logic [4:0] pa, input logic [4:0] ra,
                             input logic [15:0] wd, input logic [15:0] rd,
                             input bit intrude);
        @(negedge clk);
        start_i = 1'b1;
        is_write_i = w;
        phy_addr_i = pa;
        reg_addr_i = ra;
        wdata_i = wd;
        @(posedge clk);
        #1;
        start_i = 1'b0;
        note = intrude ? "/R10" : "";
        build(w, pa, ra, wd, rd);
        pend_is_rd = !w;
        pend_rd = rd;
        if (intrude) begin
            repeat (40) @(negedge clk);
            start_i = 1'b1;
            is_write_i = !w;
            phy_addr_i = ~pa;
            reg_addr_i = ~ra;
            wdata_i = ~wd;
            @(negedge clk);
            start_i = 1'b0;
            repeat (300) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        wait (q.size() == 0);
        repeat (2) @(negedge clk);
    endtask

    // cycle-by-cycle comparison against the queued reference
    always @(negedge clk) begin
        if (!rst) begin
            if (q.size() > 0) begin
                ent_t e;
                e = q.pop_front();
                mdi_i = e.mi;
                chk(mdc_o == e.c && mdoe_o == e.oe && mdo_o == e.o && !done_o,
                    {e.tag, "/R7", note},
                    {28'd0, mdc_o, mdoe_o, mdo_o, done_o},
                    {28'd0, e.c, e.oe, e.o, 1'b0});
                if (q.size() == 0) pend = 1;
            end else begin
                chk(!mdc_o && !mdoe_o && !mdo_o && (done_o == pend), "R9 idle/done",
                    {28'd0, mdc_o, mdoe_o, mdo_o, done_o},
                    {28'd0, 3'b000, pend});
                if (pend && pend_is_rd) exp_rd = pend_rd;
                chk(rdata_o == exp_rd, "R8 read data", {16'd0, rdata_o}, {16'd0, exp_rd});
                pend = 0;
            end
            if (!mdoe_o) chk(!mdo_o, "R11 mdo gated", {31'd0, mdo_o}, 32'd0);
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R1: reset state
        chk({mdc_o, mdoe_o, mdo_o, done_o} == 4'b0 && rdata_o == 16'h0, "R1 reset",
            {12'd0, rdata_o, mdc_o, mdoe_o, mdo_o, done_o}, 32'd0);
        run_frame(0, 5'h1F, 5'h00, 16'h0000, 16'hA5C3, 0);
        run_frame(1, 5'h15, 5'h0A, 16'h8001, 16'h0000, 0);
        run_frame(0, 5'h00, 5'h1F, 16'hFFFF, 16'hFFFF, 0);
        run_frame(1, 5'h00, 5'h00, 16'h0000, 16'h1234, 0);
        run_frame(0, 5'h0A, 5'h15, 16'h0000, 16'h0001, 1);
        run_frame(1, 5'h11, 5'h0E, 16'h7F3C, 16'h0000, 1);
        run_frame(0, 5'h03, 5'h02, 16'h0000, 16'h8000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule